// File: doc/BRIEF.md
# Channel-List ADC Sequencer Front End

This block is the register-mapped front end of a 16-channel, 12-bit analog input path. Software loads a queue of 8-bit channel descriptors, selects the software-trigger mode, and then starts each conversion by reading the start address. Every accepted start takes the oldest descriptor from the queue, shows it on `conv_entry` for the analog path to act on, and runs a conversion. A converter model inside the block returns the code present on `stub_code` at the moment of the start, a fixed number of cycles later. The result goes into a deep sample queue, and software drains that queue through the same offset it uses to load descriptors.

The bus is a single-cycle register port with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read returns `bus_rdata` combinationally in the same cycle, and its side effects take place at that edge: starting a conversion, or removing a sample. Flow control is left to software, which reads the status word to see how full each queue is. Queue overflow is handled by dropping: a descriptor written to a full list is discarded, and a result arriving at a full sample queue is discarded. One pending flag is kept for the event where the sample queue reaches half full. That flag can raise the interrupt line.

Top module: `adc_seq_fe`

## Requirements
- R1: After reset, the status word (byte offset 0x04) reads 0x0004, meaning only the sample-queue empty flag is set, and `irq` is low.
- R2: A descriptor is 8 bits: bits 3:0 select the channel, bits 5:4 the gain code, bit 6 unipolar and bit 7 differential. Descriptors written at offset 0x10 are consumed in write order. Each one appears unchanged on `conv_entry` from the cycle after its conversion is accepted.
- R3: Bits 1:0 of control word 1 (offset 0x00) select the mode: 0 off, 1 software, 2 scan, 3 external. A read of offset 0x00 starts a conversion only in mode 1. In every other mode the read has no effect.
- R4: A start read issued while a conversion is in progress is ignored. It produces no extra sample and consumes no descriptor.
- R5: A read of offset 0x10 removes the oldest sample and returns its 12-bit code in bits 11:0, with bits 15:12 zero. A read of an empty sample queue returns 0 and has no effect.
- R6: The status word has these bits: bit 0 is set while a conversion is in progress, bit 1 when the descriptor list is full, bit 2 when the sample queue is empty, bit 3 when it holds at least half its depth, and bit 4 when it is full.
- R7: The descriptor list holds 16 entries. Writes made while it is full are discarded.
- R8: In control word 2 (offset 0x02), bit 10 enables the sample queue and bit 9 enables the descriptor list. While a bit is clear, its queue is emptied and stays empty, and anything pushed into it is discarded.
- R9: When the sample queue first reaches 512 entries, status bit 8 becomes set. `irq` is high when this pending bit, control word 1 bit 15 (global enable) and bit 8 (half-full enable) are all set. Any write to offset 0x04 clears the pending bit.
- R10: The sample queue holds 1024 entries. A result that completes while the queue is full is discarded, and the stored samples are left intact.
- R11: A start read made while the descriptor list is empty does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe; its side effects occur at the clock edge |
| bus_rdata | output | 16 | Read data, valid in the cycle `bus_rd` is high |
| stub_code | input | 12 | Code the converter model returns for a conversion started now |
| conv_entry | output | 8 | Descriptor of the most recently accepted conversion |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the sample queue at its limits. Reaching the half-full event and the full queue takes 1024 completed conversions. The descriptor list is only 16 deep, so the stimulus has to refill it 64 times and issue a start read after each conversion has finished. The bench checks the half-full flag and the interrupt on each side of the 512th sample, and clears the pending bit there. It then sends one more conversion into the full queue and drains all 1024 samples, so that a dropped or overwritten result appears as a code out of sequence.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL1 = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL2 = 6'h02;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_QUEUE = 6'h10;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SW   = 2'd1,
    MODE_SCAN = 2'd2,
    MODE_EXT  = 2'd3
  } adc_mode_e;

  localparam int C1_GIE  = 15;
  localparam int C1_HFIE = 8;
  localparam int C2_SEN  = 10;
  localparam int C2_LEN  = 9;

  localparam int ST_PEND = 8;
  localparam int ST_FULL = 4;
  localparam int ST_HALF = 3;
  localparam int ST_EMPT = 2;
  localparam int ST_LFUL = 1;
  localparam int ST_ACT  = 0;
endpackage

// File: rtl/adc_seq_fifo.sv
`timescale 1ns/1ps
module adc_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               push,
  input  logic [W-1:0]       din,
  input  logic               pop,
  output logic [W-1:0]       dout,
  output logic [$clog2(DEPTH):0] count,
  output logic               empty,
  output logic               full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_conv.sv
`timescale 1ns/1ps
module adc_seq_conv #(
  parameter int DATA_W = 12,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] code_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] code_out
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      code_out <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      cnt      <= LOAD;
      code_out <= code_in;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_fe.sv
`timescale 1ns/1ps
module adc_seq_fe
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LIST_DEPTH = 16,
  parameter int SAMP_DEPTH = 1024,
  parameter int CONV_LAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  input  logic [DATA_W-1:0] stub_code,
  output logic [7:0]        conv_entry,
  output logic              irq
);
  localparam int LCW = $clog2(LIST_DEPTH) + 1;
  localparam int SCW = $clog2(SAMP_DEPTH) + 1;
  localparam logic [SCW-1:0] HALF_CNT = SCW'(SAMP_DEPTH / 2);

  logic [1:0] mode_q;
  logic       gie_q, hfie_q, sen_q, len_q;
  logic       wr_c1, wr_c2, wr_st, wr_q, rd_c1, rd_q;

  assign wr_c1 = bus_wr && (bus_addr == OFS_CTRL1);
  assign wr_c2 = bus_wr && (bus_addr == OFS_CTRL2);
  assign wr_st = bus_wr && (bus_addr == OFS_STAT);
  assign wr_q  = bus_wr && (bus_addr == OFS_QUEUE);
  assign rd_c1 = bus_rd && (bus_addr == OFS_CTRL1);
  assign rd_q  = bus_rd && (bus_addr == OFS_QUEUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      gie_q  <= 1'b0;
      hfie_q <= 1'b0;
      sen_q  <= 1'b0;
      len_q  <= 1'b0;
    end else begin
      if (wr_c1) begin
        mode_q <= bus_wdata[1:0];
        gie_q  <= bus_wdata[C1_GIE];
        hfie_q <= bus_wdata[C1_HFIE];
      end
      if (wr_c2) begin
        sen_q <= bus_wdata[C2_SEN];
        len_q <= bus_wdata[C2_LEN];
      end
    end
  end

  // descriptor list
  logic [7:0]     l_dout;
  logic [LCW-1:0] l_count;
  logic           l_empty, l_full;
  logic           start_ok;

  // sample queue
  logic [DATA_W-1:0] s_dout;
  logic [SCW-1:0]    s_count;
  logic              s_empty, s_full;

  // converter
  logic              conv_busy, conv_done;
  logic [DATA_W-1:0] conv_code;

  assign start_ok = rd_c1 && (adc_mode_e'(mode_q) == MODE_SW) && !conv_busy && !l_empty;

  adc_seq_fifo #(.W(8), .DEPTH(LIST_DEPTH)) u_list (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!len_q),
    .push  (wr_q && len_q),
    .din   (bus_wdata[7:0]),
    .pop   (start_ok),
    .dout  (l_dout),
    .count (l_count),
    .empty (l_empty),
    .full  (l_full)
  );

  adc_seq_fifo #(.W(DATA_W), .DEPTH(SAMP_DEPTH)) u_samp (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!sen_q),
    .push  (conv_done && sen_q),
    .din   (conv_code),
    .pop   (rd_q),
    .dout  (s_dout),
    .count (s_count),
    .empty (s_empty),
    .full  (s_full)
  );

  adc_seq_conv #(.DATA_W(DATA_W), .LAT(CONV_LAT)) u_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_ok),
    .code_in  (stub_code),
    .busy     (conv_busy),
    .done     (conv_done),
    .code_out (conv_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        conv_entry <= '0;
    else if (start_ok) conv_entry <= l_dout;
  end

  // half-full event and pending flag
  logic hf_now, hf_q, pend_q;
  assign hf_now = (s_count >= HALF_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hf_q <= hf_now;
      if (hf_now && !hf_q) pend_q <= 1'b1;
      else if (wr_st)      pend_q <= 1'b0;
    end
  end

  assign irq = gie_q && hfie_q && pend_q;

  logic [15:0] stat_w;
  always_comb begin
    stat_w          = '0;
    stat_w[ST_PEND] = pend_q;
    stat_w[ST_FULL] = s_full;
    stat_w[ST_HALF] = hf_now;
    stat_w[ST_EMPT] = s_empty;
    stat_w[ST_LFUL] = l_full;
    stat_w[ST_ACT]  = conv_busy;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == OFS_STAT)
        bus_rdata = stat_w;
      else if (bus_addr == OFS_QUEUE && !s_empty)
        bus_rdata = {{(16-DATA_W){1'b0}}, s_dout};
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[14:11], bus_wdata[7:2], l_count};
endmodule

// File: rtl/adc_seq_fe_chk.sv
`timescale 1ns/1ps
module adc_seq_fe_chk #(
  parameter int LCW = 5,
  parameter int SCW = 11,
  parameter int HALF = 512
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic [5:0]     bus_addr,
  input logic [15:0]    bus_rdata,
  input logic [1:0]     mode_q,
  input logic           len_q,
  input logic           conv_busy,
  input logic [LCW-1:0] l_count,
  input logic           l_full,
  input logic [SCW-1:0] s_count,
  input logic           s_full,
  input logic           irq
);
  // R3
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 6'h00 && mode_q != 2'd1 && !conv_busy |=> !conv_busy);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 6'h00 && conv_busy && !bus_wr |=> $stable(l_count));

  // R7
  list_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_full && bus_wr && bus_addr == 6'h10 && !bus_rd |=> l_full && $stable(l_count));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 6'h10 && s_count == '0 |-> bus_rdata == 16'h0000);

  // R8
  list_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !len_q && !bus_wr |=> l_count == '0);

  // R10
  samp_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_full && !bus_wr && !(bus_rd && bus_addr == 6'h10) |=> s_full);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 6'h04 && s_count >= SCW'(HALF) && $past(s_count >= SCW'(HALF)) |=> !irq);
endmodule

bind adc_seq_fe adc_seq_fe_chk #(.LCW(LCW), .SCW(SCW), .HALF(SAMP_DEPTH / 2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .mode_q    (mode_q),
  .len_q     (len_q),
  .conv_busy (conv_busy),
  .l_count   (l_count),
  .l_full    (l_full),
  .s_count   (s_count),
  .s_full    (s_full),
  .irq       (irq)
);

// File: tb/adc_seq_fe_tb.sv
`timescale 1ns/1ps
module adc_seq_fe_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic [11:0] stub_code = '0;
  logic [7:0]  conv_entry;
  logic        irq;

  int total = 0;
  int failed = 0;

  always #4 clk = ~clk;

  adc_seq_fe #(.CONV_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .stub_code(stub_code), .conv_entry(conv_entry), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic conv(input logic [11:0] c);
    logic [15:0] d;
    stub_code = c;
    rd(6'h00, d);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(6'h04, d);
    check("R1 status after reset", d, 16'h0004);
    check("R1 irq after reset", irq, 1'b0);
    rd(6'h10, d);
    check("R5 empty queue read", d, 16'h0000);
  endtask

  task automatic t_order();
    logic [15:0] d;
    wr(6'h02, 16'h0600);
    wr(6'h00, 16'h0001);
    wr(6'h10, 16'h008A);
    wr(6'h10, 16'h0045);
    wr(6'h10, 16'h003C);
    stub_code = 12'h123;
    rd(6'h00, d);
    rd(6'h04, d);
    check("R6 active during conversion", d[0], 1'b1);
    repeat (LAT + 1) @(negedge clk);
    check("R2 first descriptor", conv_entry, 8'h8A);
    conv(12'hFFF);
    check("R2 second descriptor", conv_entry, 8'h45);
    conv(12'h800);
    check("R2 third descriptor", conv_entry, 8'h3C);
    rd(6'h10, d); check("R5 sample 0", d, 16'h0123);
    rd(6'h10, d); check("R5 sample 1 upper bits zero", d, 16'h0FFF);
    rd(6'h10, d); check("R5 sample 2", d, 16'h0800);
    rd(6'h04, d); check("R6 empty after drain", d, 16'h0004);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    wr(6'h10, 16'h0077);
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        wr(6'h00, 16'(m));
        conv(12'h055);
        rd(6'h04, d);
        check($sformatf("R3 mode %0d start ignored", m), d, 16'h0004);
      end
    end
    wr(6'h00, 16'h0001);
    conv(12'h066);
    check("R3 software mode starts", conv_entry, 8'h77);
    rd(6'h10, d);
    check("R3 software mode sample", d, 16'h0066);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    wr(6'h10, 16'h0011);
    wr(6'h10, 16'h0022);
    stub_code = 12'h0AA;
    rd(6'h00, d);
    stub_code = 12'h0BB;
    rd(6'h00, d);
    repeat (LAT + 1) @(negedge clk);
    check("R4 entry of first start", conv_entry, 8'h11);
    rd(6'h10, d); check("R4 first sample", d, 16'h00AA);
    rd(6'h04, d); check("R4 no second sample", d, 16'h0004);
    conv(12'h0CC);
    check("R4 descriptor not consumed", conv_entry, 8'h22);
    rd(6'h10, d);
  endtask

  task automatic t_empty_list();
    logic [15:0] d;
    stub_code = 12'h321;
    rd(6'h00, d);
    rd(6'h04, d);
    check("R11 start with empty list", d, 16'h0004);
  endtask

  task automatic t_list_full();
    logic [15:0] d;
    for (int i = 0; i < 17; i++) wr(6'h10, 16'(i + 8'hA0));
    rd(6'h04, d);
    check("R6 list full flag", d[1], 1'b1);
    for (int i = 0; i < 16; i++) begin
      conv(12'(i));
      if (conv_entry !== 8'(i + 8'hA0)) check("R7 list entry", conv_entry, 32'(i + 8'hA0));
    end
    check("R7 sixteenth entry", conv_entry, 8'hAF);
    rd(6'h00, d);
    rd(6'h04, d);
    check("R7 seventeenth write discarded", d[1:0], 2'b00);
    for (int i = 0; i < 16; i++) rd(6'h10, d);
    rd(6'h04, d);
    check("R7 queue drained", d, 16'h0004);
  endtask

  task automatic t_flush();
    logic [15:0] d;
    wr(6'h10, 16'h0001);
    wr(6'h10, 16'h0002);
    wr(6'h02, 16'h0400);
    wr(6'h10, 16'h0003);
    wr(6'h02, 16'h0600);
    rd(6'h00, d);
    rd(6'h04, d);
    check("R8 list flushed and disabled", d, 16'h0004);
    wr(6'h10, 16'h0009);
    wr(6'h02, 16'h0200);
    conv(12'h444);
    wr(6'h02, 16'h0600);
    rd(6'h04, d);
    check("R8 result dropped while disabled", d, 16'h0004);
    wr(6'h10, 16'h000A);
    conv(12'h555);
    wr(6'h02, 16'h0200);
    wr(6'h02, 16'h0600);
    rd(6'h10, d);
    check("R8 sample queue flushed", d, 16'h0000);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    int bad = 0;
    int n = 0;
    wr(6'h00, 16'h8101);
    for (int k = 0; k < 64; k++) begin
      for (int j = 0; j < 16; j++) wr(6'h10, 16'(j));
      for (int j = 0; j < 16; j++) begin
        conv(12'((n * 5 + 3) & 12'hFFF));
        if (n == 510) begin
          rd(6'h04, d);
          check("R9 below half no flag", d[8] | d[3], 1'b0);
          check("R9 below half irq low", irq, 1'b0);
        end
        if (n == 511) begin
          rd(6'h04, d);
          check("R9 half pending", d[8], 1'b1);
          check("R6 half flag", d[3], 1'b1);
          check("R9 irq raised", irq, 1'b1);
          wr(6'h04, 16'h0000);
          check("R9 irq cleared", irq, 1'b0);
          rd(6'h04, d);
          check("R9 pending cleared", d[8], 1'b0);
        end
        n++;
      end
    end
    rd(6'h04, d);
    check("R6 full and half flags", d, 16'h0018);
    wr(6'h10, 16'h0005);
    conv(12'h777);
    rd(6'h04, d);
    check("R10 full stays full", d, 16'h0018);
    for (int i = 0; i < 1024; i++) begin
      rd(6'h10, d);
      if (d !== 16'((i * 5 + 3) & 12'hFFF)) bad++;
    end
    check("R10 drained samples intact", bad, 0);
    rd(6'h04, d);
    check("R10 empty after drain", d, 16'h0004);
    check("R9 irq low after drain", irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_modes();
    t_busy();
    t_empty_list();
    t_list_full();
    t_flush();
    t_fill();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule